// File: doc/BRIEF.md
# Runtime-Configurable Serial Receiver

This block recovers asynchronous serial frames from a single input line. Frame shape is set at run time by a small group of setup inputs: a clock-per-bit divisor, a two-bit word-length code, a stop-bit count, a parity enable, a fixed-parity select and a parity polarity bit. The same setup values would normally also drive the matching transmitter, so both ends agree on the frame.

The line passes through a two-flop synchroniser. A falling edge starts a frame, and the line is checked again half a bit later to reject glitches. Data, parity and stop bits are each sampled once, in the middle of their bit period. Data arrives least significant bit first. The received word is right-aligned in an 8-bit output, with the unused upper bits forced to zero. A one-clock valid strobe presents the word together with a parity-error flag and a framing-error flag. The setup inputs must be held steady while a frame is being received.

Top module: `uart_cfg_rx`

## Requirements
- R1: Word-length code 0, 1, 2 and 3 selects 8, 7, 6 and 5 data bits. A shorter word is presented in the low bits of `rx_data_o`, and every bit above it reads zero.
- R2: The first data bit after the start bit lands in `rx_data_o[0]`, and each later bit lands in the next higher position.
- R3: With parity enabled and fixed parity off, polarity 0 expects odd parity and polarity 1 expects even parity over the data bits plus the parity bit. A mismatch sets `rx_perr_o` for that word.
- R4: With parity enabled and fixed parity on, the received parity bit must equal the polarity input, or `rx_perr_o` is set.
- R5: With parity disabled, no parity bit is expected: the first stop bit follows the last data bit, and `rx_perr_o` is 0.
- R6: With `cfg_two_stop_i` at 0, one stop bit is sampled; with it at 1, two are sampled. A low level at any sampled stop bit sets `rx_ferr_o` for that word. With one stop bit, a new start bit may follow the stop bit directly.
- R7: A low pulse that has ended by the half-bit start re-check is discarded. It produces no strobe, and the next frame is received normally.
- R8: `rx_valid_o` goes high for exactly one clock per accepted frame, in the cycle after the final stop-bit sample. Data and flags change only together with that strobe and hold until the next one.
- R9: While reset is asserted and after it is released, `rx_valid_o`, `rx_data_o`, `rx_perr_o` and `rx_ferr_o` are all 0.
- R10: Bit timing follows `cfg_div_i` clocks per bit. Any divisor of 6 or more receives correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| cfg_div_i | input | DIV_W | Clocks per bit period |
| cfg_len_i | input | 2 | Word-length code (0: 8 bits ... 3: 5 bits) |
| cfg_two_stop_i | input | 1 | 1: two stop bits, 0: one |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_fix_i | input | 1 | Parity bit is a fixed level |
| cfg_par_sel_i | input | 1 | Polarity: odd/even when computed, fixed level when fixed |
| rx_data_o | output | 8 | Received word, right-aligned, zero-extended |
| rx_valid_o | output | 1 | One-clock strobe for a new word |
| rx_perr_o | output | 1 | Parity error for the presented word |
| rx_ferr_o | output | 1 | Framing error for the presented word |

## Verification
The strobe for a frame is due about three clocks after the middle of its last stop bit: two synchroniser flops and the sample register lie on the way, and the strobe register adds one more clock. It therefore always falls inside the last stop bit as the bench drives it. The bench drives each frame in full, including every stop bit and any idle gap. Only after that does it compare the words captured by a falling-edge monitor, expecting exactly one strobe per frame and none for a rejected glitch. Strobe width is checked on every clock by the monitor. Expected words and flags come from bench functions that use the word length, parity mode and injected errors.

// File: rtl/uart_cfg_rx.sv
module uart_cfg_rx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [1:0]       cfg_len_i,
  input  logic             cfg_two_stop_i,
  input  logic             cfg_par_en_i,
  input  logic             cfg_par_fix_i,
  input  logic             cfg_par_sel_i,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  output logic             rx_perr_o,
  output logic             rx_ferr_o
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_t;

  state_t           state;
  logic [2:0]       sync_q;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       idx;
  logic [7:0]       word_q;
  logic             pacc, perr_q, ferr_q, stop_more;

  wire             line     = sync_q[1];
  wire             fall     = sync_q[2] & ~sync_q[1];
  wire [2:0]       last_idx = 3'd7 - {1'b0, cfg_len_i};
  wire [DIV_W-1:0] half     = cfg_div_i >> 1;
  wire [DIV_W-1:0] half_end = (half == '0) ? '0 : half - 1'b1;
  wire             bit_end  = (cnt == cfg_div_i - 1'b1);
  wire             par_exp  = cfg_par_fix_i ? cfg_par_sel_i
                                            : (cfg_par_sel_i ? pacc : ~pacc);
  wire             ferr_nxt = ferr_q | ~line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], rx_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      idx        <= '0;
      word_q     <= '0;
      pacc       <= 1'b0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
      stop_more  <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      rx_perr_o  <= 1'b0;
      rx_ferr_o  <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      case (state)
        S_IDLE: if (fall) begin
          state <= S_START;
          cnt   <= '0;
        end
        S_START: if (cnt == half_end) begin
          cnt <= '0;
          if (line) state <= S_IDLE;
          else begin
            state  <= S_DATA;
            idx    <= '0;
            word_q <= '0;
            pacc   <= 1'b0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
          end
        end else cnt <= cnt + 1'b1;
        S_DATA: if (bit_end) begin
          cnt         <= '0;
          word_q[idx] <= line;
          pacc        <= pacc ^ line;
          if (idx == last_idx) begin
            state     <= cfg_par_en_i ? S_PAR : S_STOP;
            stop_more <= cfg_two_stop_i;
          end else idx <= idx + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_PAR: if (bit_end) begin
          cnt    <= '0;
          perr_q <= (line != par_exp);
          state  <= S_STOP;
        end else cnt <= cnt + 1'b1;
        S_STOP: if (bit_end) begin
          cnt <= '0;
          if (stop_more) begin
            stop_more <= 1'b0;
            ferr_q    <= ferr_nxt;
          end else begin
            state      <= S_IDLE;
            rx_valid_o <= 1'b1;
            rx_data_o  <= word_q;
            rx_perr_o  <= perr_q;
            rx_ferr_o  <= ferr_nxt;
          end
        end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_cfg_rx_chk.sv
module uart_cfg_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid,
  input logic [7:0] data,
  input logic [1:0] len,
  input logic       par_en,
  input logic       perr
);

  AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R8

  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((data >> (4'd8 - {2'b00, len})) == 8'd0)); // R1

  AST_NO_PERR_UNPARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !par_en) |-> !perr); // R5

  AST_DATA_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data) |-> valid); // R8

  AST_PERR_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(perr) |-> valid); // R8

endmodule

bind uart_cfg_rx uart_cfg_rx_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .valid  (rx_valid_o),
  .data   (rx_data_o),
  .len    (cfg_len_i),
  .par_en (cfg_par_en_i),
  .perr   (rx_perr_o)
);

// File: tb/tb_uart_cfg_rx.sv
`timescale 1ns/1ps
module tb_uart_cfg_rx;
  localparam int DIV_W = 16;
  localparam real CYC = 20.0;

  logic clk = 0, rst_n = 0, rx = 1;
  logic [DIV_W-1:0] div = 16;
  logic [1:0] len = 0;
  logic two_stop = 0, par_en = 0, par_fix = 0, par_sel = 0;
  logic [7:0] rdata;
  logic rvalid, rperr, rferr;

  int n_chk = 0, n_bad = 0;
  int n_valid = 0, n_wide = 0;
  logic prev_v = 0;
  logic [7:0] cap_d;
  logic cap_p, cap_f;

  always #(CYC/2) clk = ~clk;

  uart_cfg_rx #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .cfg_div_i(div), .cfg_len_i(len),
    .cfg_two_stop_i(two_stop), .cfg_par_en_i(par_en), .cfg_par_fix_i(par_fix),
    .cfg_par_sel_i(par_sel), .rx_data_o(rdata), .rx_valid_o(rvalid),
    .rx_perr_o(rperr), .rx_ferr_o(rferr));

  always @(negedge clk) begin
    if (rvalid) begin
      n_valid++;
      cap_d = rdata; cap_p = rperr; cap_f = rferr;
      if (prev_v) n_wide++;
    end
    prev_v = rvalid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] l);
    return 8 - l;
  endfunction

  function automatic logic [7:0] mask_word(input logic [7:0] d, input logic [1:0] l);
    return d & (8'hFF >> l);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] l,
                                   input logic fix, input logic sel);
    logic x;
    x = ^mask_word(d, l);
    return fix ? sel : (sel ? x : ~x);
  endfunction

  task automatic drive_bit(input logic b);
    rx = b;
    repeat (div) @(negedge clk);
  endtask

  // bad_stop: 0 none, 1 first stop low, 2 second stop low
  task automatic send(input logic [7:0] d, input bit bad_par, input int bad_stop, input int gap);
    drive_bit(1'b0);
    for (int i = 0; i < nbits(len); i++) drive_bit(d[i]);
    if (par_en) drive_bit(par_bit(d, len, par_fix, par_sel) ^ bad_par);
    drive_bit(bad_stop == 1 ? 1'b0 : 1'b1);
    if (two_stop) drive_bit(bad_stop == 2 ? 1'b0 : 1'b1);
    rx = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic frame_check(input logic [7:0] d, input bit bad_par, input int bad_stop,
                             input int gap, input string tag);
    int v0;
    logic [7:0] ed;
    v0 = n_valid;
    ed = mask_word(d, len);
    send(d, bad_par, bad_stop, gap);
    chk(n_valid == v0 + 1, {tag, " R8 one strobe"}, n_valid - v0, 1);
    chk(cap_d == ed, {tag, " R1 R2 R10 data"}, cap_d, ed);
    chk(cap_p == (par_en & bad_par), {tag, " R3 R4 R5 perr"}, cap_p, par_en & bad_par);
    chk(cap_f == (bad_stop != 0), {tag, " R6 ferr"}, cap_f, bad_stop != 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(rvalid == 0 && rdata == 0 && rperr == 0 && rferr == 0, "R9 in reset",
        {rvalid, rperr, rferr, rdata}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(rvalid == 0 && rdata == 0 && rperr == 0 && rferr == 0, "R9 after reset",
        {rvalid, rperr, rferr, rdata}, 0);

    // directed: 8N1 pattern for bit order
    div = 16; len = 0; par_en = 0; two_stop = 0;
    frame_check(8'hA1, 0, 0, 16, "8N1 order");
    // 5-bit word with stray upper bits in stimulus
    len = 3;
    frame_check(8'hFF, 0, 0, 16, "5N1 zext");
    // odd parity good and bad
    len = 0; par_en = 1; par_fix = 0; par_sel = 0;
    frame_check(8'h37, 0, 0, 16, "odd ok");
    frame_check(8'h37, 1, 0, 16, "odd bad");
    // even parity
    par_sel = 1;
    frame_check(8'h5C, 1, 0, 16, "even bad");
    // fixed mark/space
    par_fix = 1; par_sel = 1;
    frame_check(8'h00, 0, 0, 16, "mark ok");
    par_sel = 0;
    frame_check(8'h00, 1, 0, 16, "space bad");
    // two stop bits, second low
    par_en = 0; two_stop = 1;
    frame_check(8'h3C, 0, 2, 2*16, "2stop R6 second low");
    frame_check(8'hC3, 0, 1, 2*16, "2stop R6 first low");
    // back-to-back one stop
    two_stop = 0;
    frame_check(8'h12, 0, 0, 0, "b2b first");
    frame_check(8'h34, 0, 0, 16, "b2b second");

    // R7 glitch
    begin
      int v0;
      v0 = n_valid;
      rx = 0; repeat (2) @(negedge clk); rx = 1;
      repeat (4*16) @(negedge clk);
      chk(n_valid == v0, "R7 glitch strobe", n_valid - v0, 0);
      frame_check(8'h9E, 0, 0, 16, "R7 after glitch");
    end

    // random frames
    for (int k = 0; k < 60; k++) begin
      logic [7:0] d;
      bit bp;
      int bs;
      div      = DIV_W'(6 + $urandom_range(0, 34));
      len      = 2'($urandom_range(0, 3));
      two_stop = 1'($urandom_range(0, 1));
      par_en   = 1'($urandom_range(0, 1));
      par_fix  = 1'($urandom_range(0, 1));
      par_sel  = 1'($urandom_range(0, 1));
      d        = 8'($urandom);
      bp       = par_en && ($urandom_range(0, 3) == 0);
      bs       = ($urandom_range(0, 4) == 0) ? (two_stop ? $urandom_range(1, 2) : 1) : 0;
      repeat (4) @(negedge clk);
      frame_check(d, bp, bs, int'(div) * 2, "random");
    end

    chk(n_wide == 0, "R8 strobe width", n_wide, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CYC * 200000);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule